// File: doc/BRIEF.md
# Clock Divider with Sync Realignment

This block divides its input clock by a programmable ratio from 1 to 8. An external sync pulse can realign the phase of the divided output, so that several dividers fed from the same sync line start their output periods on the same input cycle. Software controls the block through a small register port with two 8-bit registers: a control register and a ratio register.

The control register has three live bits. The master enable must be set before any sync action can happen. The divider sync enable passes the pulse to the divider. The one-shot option limits realignment to a single pulse. Without the one-shot option, every qualified pulse resets the divider phase. With it, the first qualified pulse realigns the divider and the hardware then clears the divider sync enable, so later pulses are ignored until software sets that bit again.

The sync input may come from another clock domain. It passes through a two-flop synchronizer, and only its rising edge counts as a pulse.

Top module: `clkdiv_sync_ctrl`

## Requirements
- R1: After reset, both registers read 0x00 and `clkOut` is high.
- R2: The register map is as follows.
  - Address 0 is the control register. Bit 0 is the master enable, bit 1 is the divider sync enable and bit 2 is the one-shot option.
  - Address 1 is the ratio register. Bits 2:0 hold the ratio minus one.
  - In both registers, bits 7:3 ignore writes and read as zero.
- R3: The divide ratio N is the ratio field plus one.
  - Counting from phase zero, `clkOut` is high for ceil(N/2) input cycles and low for the rest of a period of N cycles.
  - For N = 1, `clkOut` stays high.
- R4: Take the first rising clock edge that samples `syncIn` high after it was low. On the third rising edge counted from and including that one, the divider is set to phase zero, provided the pulse is qualified. `clkOut` is then high, starting a fresh period.
- R5: While the master enable is low, sync pulses have no effect and the divider keeps its free-running phase, even if the divider sync enable is set.
- R6: While the divider sync enable is low, sync pulses have no effect on the divider phase, even with the master enable high.
- R7: In continuous mode (bits 1:0 high, bit 2 low), every qualified pulse realigns the divider and the control register keeps its value.
- R8: In one-shot mode (bits 2:0 high), the first qualified pulse realigns the divider. Bit 1 then clears itself, so the control register reads 0x05, and later pulses leave the phase unchanged.
- R9: A software write to the control register takes priority over a self-clear of bit 1 that falls on the same clock edge. The written value is the value that is kept.
- R10: If `syncIn` is held high for many cycles, it realigns the divider only once. The falling edge causes no realignment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock that is divided |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | Register address (0 = control, 1 = ratio) |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Read data of the addressed register, combinational |
| syncIn | input | 1 | Sync pulse input, may be asynchronous |
| clkOut | output | 1 | Divided clock output, registered |

## Verification
The properties assume the following about the inputs:
- `syncIn` stays at a level for at least one full input cycle, so the synchronizer sees each edge cleanly.
- The ratio register is not rewritten while a phase check is in progress.

The stimulus changes `syncIn` and the register inputs only on falling clock edges. It holds each pulse high for at least one cycle. After every ratio change it first issues a qualified pulse, and only then predicts the output phase, so each expected waveform starts from a known phase zero.

// File: rtl/clkdiv_sync_pkg.sv
package clkdiv_sync_pkg;
  localparam int REG_W  = 8;
  localparam int DIV_W  = 3;
  localparam int ADDR_W = 1;
  localparam int CTRL_W = 3;
  localparam int MAX_RATIO = 1 << DIV_W;

  localparam logic [ADDR_W-1:0] CTRL_ADDR  = 1'b0;
  localparam logic [ADDR_W-1:0] RATIO_ADDR = 1'b1;

  // strobes from the control side to the divider datapath
  typedef struct packed {
    logic             phaseReset;
    logic [DIV_W-1:0] ratioM1;
  } divCmd_t;
endpackage

// File: rtl/clkdiv_sync_regs.sv
module clkdiv_sync_regs
  import clkdiv_sync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              syncIn,
  output divCmd_t           cmd,
  output logic [CTRL_W-1:0] ctrlBits
);
  logic [SYNC_STAGES-1:0] syncPipe;
  logic                   syncLast;
  logic                   syncRise;
  logic                   masterEn;
  logic                   divSyncEn;
  logic                   oneShot;
  logic [DIV_W-1:0]       ratioM1;
  logic                   writeCtrl;
  logic                   writeRatio;
  logic                   qualified;
  logic                   unusedWdata;

  assign unusedWdata = ^regWdata[REG_W-1:CTRL_W];

  // synchronizer chain for the sync input
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_syncStage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncPipe[i] <= 1'b0;
        else       syncPipe[i] <= syncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncPipe[i] <= 1'b0;
        else       syncPipe[i] <= syncPipe[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) syncLast <= 1'b0;
    else       syncLast <= syncPipe[SYNC_STAGES-1];
  end

  assign syncRise   = syncPipe[SYNC_STAGES-1] & ~syncLast;
  assign qualified  = syncRise & masterEn & divSyncEn;
  assign writeCtrl  = regWe && (regAddr == CTRL_ADDR);
  assign writeRatio = regWe && (regAddr == RATIO_ADDR);

  // control register: a software write wins over the one-shot self-clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      masterEn  <= 1'b0;
      divSyncEn <= 1'b0;
      oneShot   <= 1'b0;
    end else if (writeCtrl) begin
      masterEn  <= regWdata[0];
      divSyncEn <= regWdata[1];
      oneShot   <= regWdata[2];
    end else if (qualified && oneShot) begin
      divSyncEn <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           ratioM1 <= '0;
    else if (writeRatio) ratioM1 <= regWdata[DIV_W-1:0];
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == CTRL_ADDR) regRdata[CTRL_W-1:0] = {oneShot, divSyncEn, masterEn};
    else                      regRdata[DIV_W-1:0]  = ratioM1;
  end

  assign cmd.phaseReset = qualified;
  assign cmd.ratioM1    = ratioM1;
  assign ctrlBits       = {oneShot, divSyncEn, masterEn};
endmodule

// File: rtl/clkdiv_sync_div.sv
module clkdiv_sync_div
  import clkdiv_sync_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  divCmd_t          cmd,
  output logic             clkOut,
  output logic [DIV_W-1:0] phase
);
  logic [DIV_W-1:0] phaseNext;
  logic [DIV_W:0]   highLen;
  logic             outNext;

  // high time is ceil(N/2), where N = ratioM1 + 1
  assign highLen = ({1'b0, cmd.ratioM1} + (DIV_W+1)'(2)) >> 1;

  always_comb begin
    if (cmd.phaseReset)             phaseNext = '0;
    else if (phase >= cmd.ratioM1)  phaseNext = '0;
    else                            phaseNext = phase + 1'b1;
  end

  assign outNext = ({1'b0, phaseNext} < highLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= '0;
      clkOut <= 1'b1;
    end else begin
      phase  <= phaseNext;
      clkOut <= outNext;
    end
  end
endmodule

// File: rtl/clkdiv_sync_ctrl.sv
module clkdiv_sync_ctrl
  import clkdiv_sync_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  input  logic              syncIn,
  output logic              clkOut
);
  divCmd_t           cmd;
  logic [CTRL_W-1:0] ctrlBits;
  logic [DIV_W-1:0]  phase;

  clkdiv_sync_regs #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .syncIn   (syncIn),
    .cmd      (cmd),
    .ctrlBits (ctrlBits)
  );

  clkdiv_sync_div u_div (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .clkOut (clkOut),
    .phase  (phase)
  );
endmodule

// File: rtl/clkdiv_sync_chk.sv
module clkdiv_sync_chk
  import clkdiv_sync_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [REG_W-1:0]  regWdata,
  input logic [REG_W-1:0]  regRdata,
  input logic              clkOut,
  input divCmd_t           cmd,
  input logic [CTRL_W-1:0] ctrlBits,
  input logic [DIV_W-1:0]  phase
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[REG_W-1:CTRL_W] == '0);

  // R3
  phase_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.phaseReset && phase < cmd.ratioM1) |=> phase == DIV_W'($past(phase) + 1'b1));

  // R4
  realign_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.phaseReset |=> (phase == '0 && clkOut));

  // R5
  master_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBits[0] |-> !cmd.phaseReset);

  // R6
  div_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBits[1] |-> !cmd.phaseReset);

  // R7
  continuous_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.phaseReset && !ctrlBits[2] && !(regWe && regAddr == CTRL_ADDR)) |=> $stable(ctrlBits));

  // R8
  oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.phaseReset && ctrlBits[2] && !(regWe && regAddr == CTRL_ADDR)) |=> !ctrlBits[1]);

  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == CTRL_ADDR) |=> ctrlBits == $past(regWdata[CTRL_W-1:0]));

  // R10
  single_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.phaseReset |=> !cmd.phaseReset);
endmodule

bind clkdiv_sync_ctrl clkdiv_sync_chk u_chk (.*);

// File: tb/tb_clkdiv_sync_ctrl.sv
module tb_clkdiv_sync_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       syncIn = 1'b0;
  logic       clkOut;

  clkdiv_sync_ctrl dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .syncIn(syncIn), .clkOut(clkOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int    cyc;
    bit    val;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  int origin = 0;
  int curN = 1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: compare clkOut against the queued expectations
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].cyc <= cyc) begin
      expItem_t e;
      e = expQ.pop_front();
      if (e.cyc == cyc) chk(e.tag, int'(clkOut), int'(e.val));
      else chk({e.tag, " missed"}, 0, 1);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(bit a, logic [7:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readChk(bit a, int exp, string tag);
    regAddr = a;
    #1;
    chk(tag, int'(regRdata), exp);
  endtask

  // driver: push the expected output for len cycles from start
  task automatic expectWin(int start, int len, string tag);
    for (int k = 0; k < len; k++) begin
      expItem_t e;
      int t;
      t = start + k;
      e.cyc = t;
      e.val = (((t - origin) % curN) < ((curN + 1) / 2));
      e.tag = tag;
      expQ.push_back(e);
    end
  endtask

  task automatic waitDrain(int lastCyc);
    while (cyc <= lastCyc) @(negedge clk);
  endtask

  // pulse; when realign is set, phase zero lands three edges later
  task automatic pulseExpect(bit realign, int len, string tag);
    int c;
    c = cyc;
    syncIn = 1'b1;
    if (realign) origin = c + 3;
    expectWin(c + 3, len, tag);
    @(negedge clk);
    syncIn = 1'b0;
    waitDrain(c + 3 + len);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : main
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    readChk(1'b0, 0, "R1 ctrl reset");
    readChk(1'b1, 0, "R1 ratio reset");
    chk("R1 clkOut reset", int'(clkOut), 1);

    // R2 reserved bits
    writeReg(1'b0, 8'hF8);
    readChk(1'b0, 0, "R2 ctrl reserved");
    writeReg(1'b1, 8'hFC);
    readChk(1'b1, 4, "R2 ratio reserved");

    // R4 realign timing, N=4, continuous
    writeReg(1'b1, 8'h03); curN = 4;
    writeReg(1'b0, 8'h03);
    idle(2);
    pulseExpect(1'b1, 8, "R4 realign N=4");

    // R3 N=5 duty
    writeReg(1'b1, 8'h04); curN = 5;
    idle(3);
    pulseExpect(1'b1, 10, "R3 N=5");
    // R7 second pulse mid-phase realigns again
    idle(2);
    pulseExpect(1'b1, 10, "R7 second pulse");
    readChk(1'b0, 3, "R7 ctrl kept");

    // R10 held-high input realigns once
    begin
      int c;
      c = cyc;
      syncIn = 1'b1;
      origin = c + 3;
      expectWin(c + 3, 20, "R10 held high");
      idle(12);
      syncIn = 1'b0;
      waitDrain(c + 23);
    end

    // R5 master off: phase kept
    writeReg(1'b0, 8'h02);
    idle(1);
    pulseExpect(1'b0, 10, "R5 master off");

    // R6 divider sync off: phase kept
    writeReg(1'b0, 8'h01);
    idle(2);
    pulseExpect(1'b0, 10, "R6 div sync off");

    // R8 one-shot
    writeReg(1'b0, 8'h07);
    idle(1);
    pulseExpect(1'b1, 10, "R8 first pulse");
    readChk(1'b0, 5, "R8 self clear");
    idle(2);
    pulseExpect(1'b0, 10, "R8 later pulse ignored");

    // R3 N=8 and N=1
    writeReg(1'b1, 8'h07); curN = 8;
    writeReg(1'b0, 8'h03);
    pulseExpect(1'b1, 16, "R3 N=8");
    writeReg(1'b1, 8'h00); curN = 1;
    idle(1);
    pulseExpect(1'b1, 6, "R3 N=1");

    // R9 write collides with self-clear
    writeReg(1'b1, 8'h04); curN = 5;
    writeReg(1'b0, 8'h07);
    begin
      int c;
      c = cyc;
      syncIn = 1'b1;
      origin = c + 3;
      expectWin(c + 3, 10, "R9 realign with write");
      @(negedge clk);
      syncIn = 1'b0;
      @(negedge clk);
      writeReg(1'b0, 8'h07);
      readChk(1'b0, 7, "R9 write wins");
      waitDrain(c + 13);
    end
    idle(1);
    pulseExpect(1'b1, 10, "R9 next pulse realigns");
    readChk(1'b0, 5, "R9 clear after");

    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule